// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Threshold

This block selects, from up to a parameterised number of external interrupt sources, the single source to present to a hart. Each source brings a pending bit, an enable bit and a small priority code. A source takes part only when it is pending, enabled and has a non-zero priority. Among those, the most urgent source wins, and equal urgency is resolved toward the smaller source number.

The block produces two views of the result. The unmasked winner (`claim_id`) ignores the threshold and is meant for the logic that serves a claim. The hart request (`hart_irq`) is raised only when the winner's priority is strictly above the programmed threshold, and `hart_id` carries the winner's number under the same masking. A parameter selects a purely combinational result or a result registered once, for timing closure.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Sources are numbered 1 to NUM_SRC. Bit i of `src_pending` and of `src_enable` belongs to source i+1, and the priority of source k sits in `src_prio[(k-1)*PRIO_W +: PRIO_W]`. A `claim_id` of 0 means no winner.
- R2: A source is eligible only when its pending bit and its enable bit are both 1. Any other source never appears on `claim_id`.
- R3: A source whose priority is 0 never wins, even when it is pending and enabled.
- R4: The winner has the largest priority value among the eligible sources.
- R5: Among eligible sources that share the largest priority, the one with the smallest number wins.
- R6: `hart_irq` is 1 exactly when a winner exists and its priority is strictly greater than `threshold`.
- R7: A threshold of 0 lets priorities 1 to 7 raise `hart_irq`, and a threshold of 7 keeps `hart_irq` low for every source.
- R8: `claim_id` does not depend on `threshold`.
- R9: `hart_id` equals `claim_id` while `hart_irq` is 1 and is 0 otherwise.
- R10: With REG_OUT=1, the outputs reflect the inputs present at the previous rising clock edge, and an active-low `rst_n` forces all three outputs to 0. With REG_OUT=0, the outputs follow the inputs without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output variant |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pending | input | NUM_SRC | Pending flag per source, bit i for source i+1 |
| src_enable | input | NUM_SRC | Enable flag per source, bit i for source i+1 |
| src_prio | input | NUM_SRC*PRIO_W | Packed priority codes, source k at slice k-1 |
| threshold | input | PRIO_W | Priority level at or below which the hart is not interrupted |
| claim_id | output | ID_W | Winning source number regardless of threshold, 0 for none |
| hart_irq | output | 1 | Interrupt request to the hart |
| hart_id | output | ID_W | Winning source number when the request is raised, else 0 |

## Verification
The bench builds the block at its full size, 127 sources with 3-bit priorities and a 7-bit ID, and with the registered output. This puts the highest source number, the padded leaf of the 128-leaf tree, and the one-cycle latency and reset behaviour within reach. Directed cases cover ties spread across distant subtrees, priority-0 sources, all eight threshold values against a fixed winner, and the cycle before new inputs take effect. Dense and sparse random patterns then exercise both the idle case and crowded arbitration.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   localparam int unsigned PRIO_W_DEF = 3;

   // smallest power of two not below n (at least 1)
   function automatic int unsigned pow2_ceil(input int unsigned n);
      int unsigned p;
      p = 1;
      for (int i = 0; i < 32; i++) begin
         if (p < n) p = p << 1;
      end
      return p;
   endfunction

endpackage

// File: rtl/irq_arb_leaf.sv
module irq_arb_leaf #(
   parameter int unsigned PRIO_W = 3,
   parameter int unsigned ID_W   = 7,
   parameter int unsigned SRC_ID = 1
) (
   input  logic              pending,
   input  logic              enable,
   input  logic [PRIO_W-1:0] prio,
   output logic [PRIO_W-1:0] cand_prio,
   output logic [ID_W-1:0]   cand_id
);
   // priority 0 folds into "not eligible": an empty candidate is prio 0, id 0
   logic eligible;

   assign eligible  = pending & enable & (prio != '0);
   assign cand_prio = eligible ? prio : '0;
   assign cand_id   = eligible ? ID_W'(SRC_ID) : '0;

endmodule

// File: rtl/irq_arb_node.sv
module irq_arb_node #(
   parameter int unsigned PRIO_W = 3,
   parameter int unsigned ID_W   = 7
) (
   input  logic [PRIO_W-1:0] lo_prio,
   input  logic [ID_W-1:0]   lo_id,
   input  logic [PRIO_W-1:0] hi_prio,
   input  logic [ID_W-1:0]   hi_id,
   output logic [PRIO_W-1:0] out_prio,
   output logic [ID_W-1:0]   out_id
);
   // the lo side always holds the smaller IDs, so only a strictly larger
   // priority on the hi side may displace it
   logic take_hi;

   assign take_hi  = hi_prio > lo_prio;
   assign out_prio = take_hi ? hi_prio : lo_prio;
   assign out_id   = take_hi ? hi_id   : lo_id;

endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_SRC = 127,
   parameter int unsigned PRIO_W  = PRIO_W_DEF,
   parameter int unsigned ID_W    = 7
) (
   input  logic [NUM_SRC-1:0]        pend,
   input  logic [NUM_SRC-1:0]        en,
   input  logic [NUM_SRC*PRIO_W-1:0] prio,
   output logic [PRIO_W-1:0]         win_prio,
   output logic [ID_W-1:0]           win_id
);
   localparam int unsigned LEAVES     = pow2_ceil(NUM_SRC);
   localparam int unsigned NODES      = 2 * LEAVES - 1;
   localparam int unsigned FIRST_LEAF = LEAVES - 1;

   // heap layout: node k has children 2k+1 (lower IDs) and 2k+2
   logic [PRIO_W-1:0] n_prio [NODES];
   logic [ID_W-1:0]   n_id   [NODES];

   generate
      for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
         if (i < NUM_SRC) begin : g_real
            irq_arb_leaf #(
               .PRIO_W (PRIO_W),
               .ID_W   (ID_W),
               .SRC_ID (i + 1)
            ) u_leaf (
               .pending   (pend[i]),
               .enable    (en[i]),
               .prio      (prio[i*PRIO_W +: PRIO_W]),
               .cand_prio (n_prio[FIRST_LEAF+i]),
               .cand_id   (n_id[FIRST_LEAF+i])
            );
         end else begin : g_pad
            assign n_prio[FIRST_LEAF+i] = '0;
            assign n_id[FIRST_LEAF+i]   = '0;
         end
      end

      for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
         irq_arb_node #(
            .PRIO_W (PRIO_W),
            .ID_W   (ID_W)
         ) u_node (
            .lo_prio  (n_prio[2*k+1]),
            .lo_id    (n_id[2*k+1]),
            .hi_prio  (n_prio[2*k+2]),
            .hi_id    (n_id[2*k+2]),
            .out_prio (n_prio[k]),
            .out_id   (n_id[k])
         );
      end
   endgenerate

   assign win_prio = n_prio[0];
   assign win_id   = n_id[0];

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_SRC = 127,
   parameter int unsigned PRIO_W  = PRIO_W_DEF,
   parameter int unsigned ID_W    = $clog2(NUM_SRC + 1),
   parameter int unsigned REG_OUT = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        src_pending,
   input  logic [NUM_SRC-1:0]        src_enable,
   input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
   input  logic [PRIO_W-1:0]         threshold,
   output logic [ID_W-1:0]           claim_id,
   output logic                      hart_irq,
   output logic [ID_W-1:0]           hart_id
);
   generate
      if (NUM_SRC < 1) begin : g_bad_count
         $error("irq_prio_arbiter: NUM_SRC must be at least 1");
      end
      if (NUM_SRC > (1 << ID_W) - 1) begin : g_bad_idw
         $error("irq_prio_arbiter: ID_W too narrow for NUM_SRC");
      end
      if (PRIO_W < 1) begin : g_bad_prio
         $error("irq_prio_arbiter: PRIO_W must be at least 1");
      end
      if (REG_OUT > 1) begin : g_bad_reg
         $error("irq_prio_arbiter: REG_OUT must be 0 or 1");
      end
   endgenerate

   logic [PRIO_W-1:0] win_prio;
   logic [ID_W-1:0]   win_id;
   logic              nxt_irq;
   logic [ID_W-1:0]   nxt_hart_id;

   irq_arb_tree #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .ID_W    (ID_W)
   ) u_tree (
      .pend     (src_pending),
      .en       (src_enable),
      .prio     (src_prio),
      .win_prio (win_prio),
      .win_id   (win_id)
   );

   // an empty result carries priority 0, which no threshold can exceed
   assign nxt_irq     = win_prio > threshold;
   assign nxt_hart_id = nxt_irq ? win_id : '0;

   generate
      if (REG_OUT != 0) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               claim_id <= '0;
               hart_irq <= 1'b0;
               hart_id  <= '0;
            end else begin
               claim_id <= win_id;
               hart_irq <= nxt_irq;
               hart_id  <= nxt_hart_id;
            end
         end
      end else begin : g_comb
         assign claim_id = win_id;
         assign hart_irq = nxt_irq;
         assign hart_id  = nxt_hart_id;
      end
   endgenerate

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
   parameter int unsigned NUM_SRC = 127,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned ID_W    = 7,
   parameter int unsigned REG_OUT = 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_SRC-1:0]        src_pending,
   input logic [NUM_SRC-1:0]        src_enable,
   input logic [NUM_SRC*PRIO_W-1:0] src_prio,
   input logic [PRIO_W-1:0]         threshold,
   input logic [ID_W-1:0]           claim_id,
   input logic                      hart_irq,
   input logic [ID_W-1:0]           hart_id
);
   // inputs aligned to the cycle the outputs describe
   logic [NUM_SRC-1:0]        d_pend;
   logic [NUM_SRC-1:0]        d_en;
   logic [NUM_SRC*PRIO_W-1:0] d_prio;
   logic [PRIO_W-1:0]         d_thr;
   logic                      d_vld;

   generate
      if (REG_OUT != 0) begin : g_dly
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d_vld  <= 1'b0;
               d_pend <= '0;
               d_en   <= '0;
               d_prio <= '0;
               d_thr  <= '0;
            end else begin
               d_vld  <= 1'b1;
               d_pend <= src_pending;
               d_en   <= src_enable;
               d_prio <= src_prio;
               d_thr  <= threshold;
            end
         end

         // R10: reset clears every output
         assert_reset_clear_R10: assert property (@(posedge clk)
            !rst_n |=> (claim_id == '0 && !hart_irq && hart_id == '0));
      end else begin : g_nodly
         assign d_vld  = 1'b1;
         assign d_pend = src_pending;
         assign d_en   = src_enable;
         assign d_prio = src_prio;
         assign d_thr  = threshold;
      end
   endgenerate

   logic [PRIO_W-1:0] top_p;
   logic [ID_W-1:0]   first_id;
   logic [PRIO_W-1:0] win_p;
   logic              win_elig;

   always_comb begin
      top_p    = '0;
      first_id = '0;
      win_p    = '0;
      win_elig = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         logic [PRIO_W-1:0] p;
         p = d_prio[i*PRIO_W +: PRIO_W];
         if (d_pend[i] && d_en[i] && p > top_p) begin
            top_p    = p;
            first_id = ID_W'(i + 1);
         end
         if (ID_W'(i + 1) == claim_id) begin
            win_p    = p;
            win_elig = d_pend[i] && d_en[i];
         end
      end
   end

   assert_winner_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n || !d_vld)
      claim_id != '0 |-> win_elig);

   assert_prio_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n || !d_vld)
      claim_id != '0 |-> win_p != '0);

   assert_top_priority_R4: assert property (@(posedge clk) disable iff (!rst_n || !d_vld)
      win_p == top_p);

   assert_lowest_id_R5: assert property (@(posedge clk) disable iff (!rst_n || !d_vld)
      claim_id == first_id);

   assert_irq_threshold_R6: assert property (@(posedge clk) disable iff (!rst_n || !d_vld)
      hart_irq == (claim_id != '0 && win_p > d_thr));

   assert_hart_id_R9: assert property (@(posedge clk) disable iff (!rst_n || !d_vld)
      hart_id == (hart_irq ? claim_id : '0));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
   .NUM_SRC (NUM_SRC),
   .PRIO_W  (PRIO_W),
   .ID_W    (ID_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_pending (src_pending),
   .src_enable  (src_enable),
   .src_prio    (src_prio),
   .threshold   (threshold),
   .claim_id    (claim_id),
   .hart_irq    (hart_irq),
   .hart_id     (hart_id)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
   localparam int N  = 127;
   localparam int PW = 3;
   localparam int IW = 7;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    pend = '0;
   logic [N-1:0]    en = '0;
   logic [N*PW-1:0] prio = '0;
   logic [PW-1:0]   thr = '0;
   logic [IW-1:0]   claim_id;
   logic            hart_irq;
   logic [IW-1:0]   hart_id;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   irq_prio_arbiter #(
      .NUM_SRC (N),
      .PRIO_W  (PW),
      .ID_W    (IW),
      .REG_OUT (1)
   ) u_irq_prio_arbiter (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_pending (pend),
      .src_enable  (en),
      .src_prio    (prio),
      .threshold   (thr),
      .claim_id    (claim_id),
      .hart_irq    (hart_irq),
      .hart_id     (hart_id)
   );

   task automatic clear_all();
      pend = '0;
      en   = '0;
      prio = '0;
   endtask

   task automatic set_src(int id, bit p, bit e, int pr);
      pend[id-1] = p;
      en[id-1]   = e;
      prio[(id-1)*PW +: PW] = PW'(pr);
   endtask

   // behavioural reference: scan IDs upward, keep a strictly larger priority
   function automatic void model(output int e_id, output bit e_irq, output int e_hid);
      int best_p;
      best_p = 0;
      e_id   = 0;
      for (int id = 1; id <= N; id++) begin
         int p;
         p = int'(prio[(id-1)*PW +: PW]);
         if (pend[id-1] && en[id-1] && p > best_p) begin
            best_p = p;
            e_id   = id;
         end
      end
      e_irq = best_p > int'(thr);
      e_hid = e_irq ? e_id : 0;
   endfunction

   task automatic expect_out(string req, int e_id, bit e_irq, int e_hid);
      checks++;
      if (int'(claim_id) != e_id || hart_irq != e_irq || int'(hart_id) != e_hid) begin
         fails++;
         $display("FAIL %s: claim_id=%0d hart_irq=%0d hart_id=%0d expected claim_id=%0d hart_irq=%0d hart_id=%0d",
                  req, claim_id, hart_irq, hart_id, e_id, e_irq, e_hid);
      end
   endtask

   // inputs are set at a falling edge; they are captured at the next rising
   // edge and the registered result is sampled at the falling edge after it
   task automatic cycle(string req);
      int  e_id;
      bit  e_irq;
      int  e_hid;
      model(e_id, e_irq, e_hid);
      @(posedge clk);
      @(negedge clk);
      expect_out(req, e_id, e_irq, e_hid);
   endtask

   initial begin
      #(4 * 50000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // R10: reset holds all outputs at 0 even with an eligible source
      set_src(4, 1, 1, 6);
      repeat (3) begin
         @(negedge clk);
         expect_out("R10", 0, 0, 0);
      end
      rst_n = 1'b1;
      clear_all();
      thr = '0;

      // R1: lowest and highest source numbers, priority slice position
      set_src(1, 1, 1, 3);
      cycle("R1");
      expect_out("R1", 1, 1, 1);
      clear_all();
      set_src(127, 1, 1, 1);
      cycle("R1");
      expect_out("R1", 127, 1, 127);

      // R2: pending-only and enabled-only sources do not take part
      clear_all();
      set_src(5, 1, 0, 7);
      set_src(6, 0, 1, 7);
      cycle("R2");
      expect_out("R2", 0, 0, 0);
      set_src(6, 1, 1, 2);
      cycle("R2");
      expect_out("R2", 6, 1, 6);

      // R3: priority 0 never wins
      clear_all();
      set_src(3, 1, 1, 0);
      set_src(9, 1, 1, 0);
      cycle("R3");
      expect_out("R3", 0, 0, 0);
      set_src(60, 1, 1, 1);
      cycle("R3");
      expect_out("R3", 60, 1, 60);

      // R4: highest priority wins regardless of position
      clear_all();
      set_src(10, 1, 1, 2);
      set_src(11, 1, 1, 5);
      set_src(100, 1, 1, 6);
      cycle("R4");
      expect_out("R4", 100, 1, 100);

      // R5: tie at top priority goes to the smallest number
      clear_all();
      set_src(90, 1, 1, 5);
      set_src(50, 1, 1, 5);
      set_src(20, 1, 1, 5);
      set_src(2, 1, 1, 4);
      cycle("R5");
      expect_out("R5", 20, 1, 20);
      set_src(20, 1, 0, 5);
      cycle("R5");
      expect_out("R5", 50, 1, 50);

      // R6 and R9: request needs priority strictly above threshold
      clear_all();
      set_src(33, 1, 1, 4);
      thr = 3'd3;
      cycle("R6");
      expect_out("R6", 33, 1, 33);
      thr = 3'd4;
      cycle("R6");
      expect_out("R9", 33, 0, 0);
      thr = 3'd5;
      cycle("R6");
      expect_out("R9", 33, 0, 0);

      // R7: threshold extremes
      clear_all();
      set_src(7, 1, 1, 1);
      thr = 3'd0;
      cycle("R7");
      expect_out("R7", 7, 1, 7);
      set_src(7, 1, 1, 7);
      thr = 3'd7;
      cycle("R7");
      expect_out("R7", 7, 0, 0);
      thr = 3'd6;
      cycle("R7");
      expect_out("R7", 7, 1, 7);

      // R8: claim_id stays fixed across every threshold value
      clear_all();
      set_src(42, 1, 1, 5);
      set_src(43, 1, 1, 3);
      for (int t = 0; t < 8; t++) begin
         thr = PW'(t);
         cycle("R8");
         expect_out("R8", 42, (5 > t), (5 > t) ? 42 : 0);
      end

      // R10: new inputs take effect only after the next rising edge
      clear_all();
      #1;
      expect_out("R10", 42, 0, 0);
      cycle("R10");
      expect_out("R10", 0, 0, 0);

      // R4: dense and sparse random patterns against the reference
      for (int n = 0; n < 400; n++) begin
         bit sparse;
         sparse = (n % 3) == 0;
         for (int i = 0; i < N; i++) begin
            if (sparse) begin
               pend[i] = ($urandom_range(0, 40) == 0);
               en[i]   = ($urandom_range(0, 1) == 1);
            end else begin
               pend[i] = ($urandom_range(0, 1) == 1);
               en[i]   = ($urandom_range(0, 3) != 0);
            end
            prio[i*PW +: PW] = PW'($urandom_range(0, 7));
         end
         thr = PW'($urandom_range(0, 7));
         cycle("R4");
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule